// File: doc/BRIEF.md
# Power-On Reset and Watchdog Supervisor

This block drives the reset and watchdog outputs of a processor supervisor. A digital supply-low flag from an external comparator holds the system in reset. When the flag clears, reset stays asserted for a power-on delay picked from four options by a 2-bit code. Reset is given in both polarities.

A watchdog runs while the system is out of reset. Software keeps it alive by producing a start condition on a two-wire serial bus: SDA falling while SCL is high. If no start condition arrives within the chosen interval, the active-low watchdog flag goes low. It stays low until the timer is restarted. The interval is also picked by a 2-bit code, and one code value turns the watchdog off.

All delays are counted in pulses of a timebase enable input (nominally one per millisecond). Faster pulses shorten every delay in proportion.

Top module: `sup_supervisor`

## Requirements
- R1: The power-on delay code maps 0, 1, 2, 3 to 50, 200, 400 and 800 timebase pulses. After the supply-low flag is seen clear, reset deasserts on the clock edge that counts the last of those pulses.
- R2: Reset asserts on the first clock edge that samples the supply-low flag high, and stays asserted for as long as the flag stays high.
- R3: The active-low reset output is always the complement of the active-high reset output. Both show reset while the block's own reset input is low.
- R4: SCL and SDA each pass through a two-stage synchronizer. A start condition (synchronized SDA falling while synchronized SCL is high) clears the watchdog count on the third clock edge after SDA falls at the pin.
- R5: SDA falling while SCL is low is not a start condition, and neither is SDA rising while SCL is high. Neither one changes when the watchdog expires.
- R6: The watchdog code maps 0, 1 and 2 to 25, 200 and 1400 timebase pulses. The watchdog flag drops on the edge that counts the last pulse after a restart.
- R7: Watchdog code 3 turns the watchdog off: the count is held clear and the flag stays high.
- R8: Once low, the watchdog flag stays low until a restart. A start condition releases it on the same edge that clears the count.
- R9: While reset is asserted, the watchdog is held clear and its flag is high. Counting begins on the first edge after reset deasserts.
- R10: A change of the watchdog code restarts the count on the edge that first samples the new code.
- R11: Counters advance only on clock edges where the timebase input is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_n_i | input | 1 | Synchronous active-low block reset |
| tick_i | input | 1 | Timebase enable pulse, one clock wide |
| supply_low_i | input | 1 | Supply-low flag from the external comparator, high = low supply |
| scl_i | input | 1 | Serial bus clock line, sampled |
| sda_i | input | 1 | Serial bus data line, sampled |
| por_sel_i | input | 2 | Power-on delay code |
| wd_sel_i | input | 2 | Watchdog interval code, 3 = off |
| rst_o | output | 1 | System reset, active high |
| rst_n_o | output | 1 | System reset, active low |
| wdo_n_o | output | 1 | Watchdog timeout flag, active low |

## Verification
The power-on delay is measured as an exact number of clocks for all four codes with a pulse on every clock. It is measured again with pulses every fourth clock, which shows that counting follows the timebase and not the clock. The watchdog is timed from reset release for each active code. It is then disturbed in several ways: a real start condition late in the interval, which must shift the expiry by the restart time plus the synchronizer delay; a look-alike pattern of SDA falling under low SCL followed by a stop, which must leave the expiry where it was; and a code change in mid-count. A timeout is held and then cleared by a start condition, which separates a latched flag from a pulsed one. The off code and a supply dip during a timeout show that reset and the off setting override the watchdog.

// File: rtl/sup_pkg.sv
// Package: shared code values for the supervisor.
// Assumes 2-bit selection codes on both delay selectors.
package sup_pkg;
    typedef enum logic [1:0] {
        WD_SHORT = 2'd0,
        WD_MID   = 2'd1,
        WD_LONG  = 2'd2,
        WD_OFF   = 2'd3
    } wd_sel_e;

    localparam int SEL_W = 2;
endpackage

// File: rtl/sup_start_detect.sv
// Synchronizes SCL and SDA and flags a bus start condition (SDA falling
// while SCL is high) as a single-cycle pulse. Assumes both lines idle high.
module sup_start_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic scl_i,
    input  logic sda_i,
    output logic start_o
);
    logic [SYNC_STAGES-1:0] scl_sync;
    logic [SYNC_STAGES-1:0] sda_sync;
    logic                   sda_prev;

    // Synchronizer chains: shift the pin values in, reset to the idle level.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            scl_sync <= '1;
            sda_sync <= '1;
        end else begin
            scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
            sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
        end
    end

    // Previous synchronized SDA, used for falling-edge detection.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) sda_prev <= 1'b1;
        else          sda_prev <= sda_sync[SYNC_STAGES-1];
    end

    // Start pulse: synchronized SDA falls while synchronized SCL is high.
    always_comb begin
        start_o = scl_sync[SYNC_STAGES-1] && sda_prev && !sda_sync[SYNC_STAGES-1];
    end
endmodule

// File: rtl/sup_por_timer.sv
// Holds reset while the supply is low, then for lim_i timebase pulses
// after the supply flag clears. Assumes lim_i >= 1.
module sup_por_timer #(
    parameter int CNT_W = 11
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             tick_i,
    input  logic             supply_low_i,
    input  logic [CNT_W-1:0] lim_i,
    output logic             rst_act_o
);
    logic [CNT_W-1:0] cnt;
    logic             hold;

    // Reset hold state and delay counter.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i || supply_low_i) begin
            hold <= 1'b1;
            cnt  <= '0;
        end else if (hold && tick_i) begin
            if (cnt == lim_i - 1'b1) begin
                hold <= 1'b0;
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Drive the reset request out.
    always_comb rst_act_o = hold;
endmodule

// File: rtl/sup_wdog_timer.sv
// Watchdog counter: restarts on a start pulse, on a code change or while
// reset is active. It latches the low flag on expiry and the off code
// disables it. Assumes lim_i >= 1 for active codes.
module sup_wdog_timer #(
    parameter int CNT_W = 11
) (
    input  logic                   clk_i,
    input  logic                   rst_n_i,
    input  logic                   tick_i,
    input  logic                   rst_act_i,
    input  logic                   start_i,
    input  sup_pkg::wd_sel_e       sel_i,
    input  logic [CNT_W-1:0]       lim_i,
    output logic                   wdo_n_o
);
    import sup_pkg::*;

    logic [CNT_W-1:0] cnt;
    logic             flag_n;
    wd_sel_e          sel_q;
    logic             restart;

    // Restart conditions gathered into one term.
    always_comb begin
        restart = rst_act_i || start_i || (sel_i != sel_q) || (sel_i == WD_OFF);
    end

    // Remember the last code to notice a change.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) sel_q <= sel_i;
        else          sel_q <= sel_i;
    end

    // Count timebase pulses and latch the timeout flag.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i || restart) begin
            cnt    <= '0;
            flag_n <= 1'b1;
        end else if (tick_i && flag_n) begin
            if (cnt == lim_i - 1'b1) begin
                flag_n <= 1'b0;
                cnt    <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Drive the flag out.
    always_comb wdo_n_o = flag_n;
endmodule

// File: rtl/sup_supervisor.sv
// Top level: power-on reset generation with a selectable delay, plus a
// bus-start watchdog with a selectable interval. All delays are counted
// in timebase pulses. Assumes a synchronous active-low block reset.
module sup_supervisor #(
    parameter int POR_T0 = 50,
    parameter int POR_T1 = 200,
    parameter int POR_T2 = 400,
    parameter int POR_T3 = 800,
    parameter int WD_T0  = 25,
    parameter int WD_T1  = 200,
    parameter int WD_T2  = 1400,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk_i,
    input  logic       rst_n_i,
    input  logic       tick_i,
    input  logic       supply_low_i,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [1:0] por_sel_i,
    input  logic [1:0] wd_sel_i,
    output logic       rst_o,
    output logic       rst_n_o,
    output logic       wdo_n_o
);
    import sup_pkg::*;

    localparam int POR_MAX = (POR_T0 > POR_T1 ? POR_T0 : POR_T1) > (POR_T2 > POR_T3 ? POR_T2 : POR_T3)
                           ? (POR_T0 > POR_T1 ? POR_T0 : POR_T1) : (POR_T2 > POR_T3 ? POR_T2 : POR_T3);
    localparam int WD_MAX  = (WD_T0 > WD_T1 ? WD_T0 : WD_T1) > WD_T2 ? (WD_T0 > WD_T1 ? WD_T0 : WD_T1) : WD_T2;
    localparam int LIM_MAX = POR_MAX > WD_MAX ? POR_MAX : WD_MAX;
    localparam int CNT_W   = $clog2(LIM_MAX + 1);

    logic [CNT_W-1:0] por_lim;
    logic [CNT_W-1:0] wd_lim;
    logic             start;
    logic             rst_act;
    wd_sel_e          wd_sel;

    // Decode the delay codes into pulse counts.
    always_comb begin
        wd_sel = wd_sel_e'(wd_sel_i);
        case (por_sel_i)
            2'd0:    por_lim = CNT_W'(POR_T0);
            2'd1:    por_lim = CNT_W'(POR_T1);
            2'd2:    por_lim = CNT_W'(POR_T2);
            default: por_lim = CNT_W'(POR_T3);
        endcase
        case (wd_sel)
            WD_SHORT: wd_lim = CNT_W'(WD_T0);
            WD_MID:   wd_lim = CNT_W'(WD_T1);
            WD_LONG:  wd_lim = CNT_W'(WD_T2);
            default:  wd_lim = CNT_W'(WD_T2);
        endcase
    end

    sup_start_detect #(.SYNC_STAGES(SYNC_STAGES)) start_det_i (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .start_o (start)
    );

    sup_por_timer #(.CNT_W(CNT_W)) por_i (
        .clk_i        (clk_i),
        .rst_n_i      (rst_n_i),
        .tick_i       (tick_i),
        .supply_low_i (supply_low_i),
        .lim_i        (por_lim),
        .rst_act_o    (rst_act)
    );

    sup_wdog_timer #(.CNT_W(CNT_W)) wdog_i (
        .clk_i     (clk_i),
        .rst_n_i   (rst_n_i),
        .tick_i    (tick_i),
        .rst_act_i (rst_act),
        .start_i   (start),
        .sel_i     (wd_sel),
        .lim_i     (wd_lim),
        .wdo_n_o   (wdo_n_o)
    );

    // Both reset polarities from the single hold state.
    always_comb begin
        rst_o   = rst_act;
        rst_n_o = !rst_act;
    end
endmodule

// File: rtl/sup_supervisor_chk.sv
// Checker for sup_supervisor, attached by bind. Observes ports only.
module sup_supervisor_chk (
    input logic       clk_i,
    input logic       rst_n_i,
    input logic       tick_i,
    input logic       supply_low_i,
    input logic [1:0] wd_sel_i,
    input logic       rst_o,
    input logic       rst_n_o,
    input logic       wdo_n_o
);
    AST_SUPPLY_LOW_RESETS: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        supply_low_i |=> rst_o);                                            // R2
    AST_POLARITY_PAIR: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        rst_o != rst_n_o);                                                  // R3
    AST_RELEASE_NEEDS_SUPPLY: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $fell(rst_o) |-> !$past(supply_low_i));                             // R1
    AST_WDOG_OFF_HIGH: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (wd_sel_i == 2'd3) |=> wdo_n_o);                                    // R7
    AST_RESET_HOLDS_WDOG: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        rst_o |=> wdo_n_o);                                                 // R9
    AST_WDO_FALLS_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $fell(wdo_n_o) |-> $past(tick_i));                                  // R11
endmodule

bind sup_supervisor sup_supervisor_chk chk_i (
    .clk_i        (clk_i),
    .rst_n_i      (rst_n_i),
    .tick_i       (tick_i),
    .supply_low_i (supply_low_i),
    .wd_sel_i     (wd_sel_i),
    .rst_o        (rst_o),
    .rst_n_o      (rst_n_o),
    .wdo_n_o      (wdo_n_o)
);

// File: tb/sup_supervisor_tb_top.sv
// Directed bench for sup_supervisor: one task per scenario.
module sup_supervisor_tb_top;
    logic       clk_i = 1'b0;
    logic       rst_n_i = 1'b0;
    logic       tick_i = 1'b1;
    logic       supply_low_i = 1'b1;
    logic       scl_i = 1'b1;
    logic       sda_i = 1'b1;
    logic [1:0] por_sel_i = 2'd0;
    logic [1:0] wd_sel_i = 2'd0;
    logic       rst_o;
    logic       rst_n_o;
    logic       wdo_n_o;

    int checks = 0;
    int errors = 0;
    int tick_div = 1;
    int cyc = 0;
    bit done = 0;

    always #2.5 clk_i = ~clk_i;

    sup_supervisor dut_i (
        .clk_i(clk_i), .rst_n_i(rst_n_i), .tick_i(tick_i),
        .supply_low_i(supply_low_i), .scl_i(scl_i), .sda_i(sda_i),
        .por_sel_i(por_sel_i), .wd_sel_i(wd_sel_i),
        .rst_o(rst_o), .rst_n_o(rst_n_o), .wdo_n_o(wdo_n_o)
    );

    // Timebase: pulse on cycles divisible by tick_div.
    always @(negedge clk_i) begin
        cyc++;
        tick_i = (tick_div == 1) || (cyc % tick_div == 0);
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_rst_low(output int n);
        n = 0;
        do begin @(negedge clk_i); n++; end while (rst_o && n < 5000);
    endtask

    task automatic wait_wdo_low(output int n);
        n = 0;
        do begin @(negedge clk_i); n++; end while (wdo_n_o && n < 5000);
    endtask

    task automatic power_cycle(input logic [1:0] psel, output int n);
        @(negedge clk_i); supply_low_i = 1'b1; por_sel_i = psel;
        @(negedge clk_i); @(negedge clk_i);
        supply_low_i = 1'b0;
        wait_rst_low(n);
    endtask

    task automatic bus_idle();
        @(negedge clk_i); scl_i = 1'b0;
        @(negedge clk_i); sda_i = 1'b1;
        @(negedge clk_i); scl_i = 1'b1;
    endtask

    task automatic t_reset_state();
        repeat (3) @(negedge clk_i);
        check(rst_o == 1 && rst_n_o == 0 && wdo_n_o == 1, "R3 reset state", {rst_o, rst_n_o, wdo_n_o}, 3'b101);
        rst_n_i = 1'b1;
        @(negedge clk_i);
        check(rst_o == 1, "R2 held while supply low", rst_o, 1);
    endtask

    task automatic t_por_codes();
        int exp_t[4] = '{50, 200, 400, 800};
        int n;
        for (int c = 0; c < 4; c++) begin
            power_cycle(c[1:0], n);
            check(n == exp_t[c], "R1 power-on delay", n, exp_t[c]);
            check(rst_n_o == 1 && rst_o == 0, "R3 polarity after release", rst_n_o, 1);
        end
    endtask

    task automatic t_wd_codes();
        int exp_t[3] = '{25, 200, 1400};
        int n;
        for (int c = 0; c < 3; c++) begin
            wd_sel_i = c[1:0];
            power_cycle(2'd0, n);
            wait_wdo_low(n);
            check(n == exp_t[c], "R6 watchdog interval", n, exp_t[c]);
        end
    endtask

    task automatic t_latch_and_start();
        int n;
        repeat (40) @(negedge clk_i);
        check(wdo_n_o == 0, "R8 flag stays low", wdo_n_o, 0);
        sda_i = 1'b0;
        n = 0;
        do begin @(negedge clk_i); n++; end while (!wdo_n_o && n < 20);
        check(n == 3, "R8 start releases flag", n, 3);
        bus_idle();
    endtask

    task automatic t_start_restart();
        int n;
        wd_sel_i = 2'd0;
        power_cycle(2'd0, n);
        repeat (15) @(negedge clk_i);
        sda_i = 1'b0;
        wait_wdo_low(n);
        check(n == 28, "R4 start restarts count", n, 28);
        bus_idle();
    endtask

    task automatic t_false_start();
        int n;
        wd_sel_i = 2'd0;
        power_cycle(2'd0, n);
        n = 0;
        do begin
            @(negedge clk_i); n++;
            if (n == 5) scl_i = 1'b0;
            if (n == 6) sda_i = 1'b0;
            if (n == 7) scl_i = 1'b1;
            if (n == 8) sda_i = 1'b1;
        end while (wdo_n_o && n < 5000);
        check(n == 25, "R5 no start from low-SCL fall or stop", n, 25);
    endtask

    task automatic t_off();
        int n;
        int lows = 0;
        wd_sel_i = 2'd3;
        power_cycle(2'd0, n);
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk_i);
            if (!wdo_n_o) lows++;
        end
        check(lows == 0, "R7 off code keeps flag high", lows, 0);
    endtask

    task automatic t_change();
        int n;
        wd_sel_i = 2'd1;
        power_cycle(2'd0, n);
        repeat (50) @(negedge clk_i);
        wd_sel_i = 2'd0;
        wait_wdo_low(n);
        check(n == 26, "R10 code change restarts", n, 26);
    endtask

    task automatic t_reset_hold();
        int n;
        int lows = 0;
        wd_sel_i = 2'd0;
        power_cycle(2'd0, n);
        wait_wdo_low(n);
        supply_low_i = 1'b1;
        @(negedge clk_i);
        check(rst_o == 1, "R2 reset on next edge", rst_o, 1);
        @(negedge clk_i);
        check(wdo_n_o == 1, "R9 reset clears flag", wdo_n_o, 1);
        for (int i = 0; i < 100; i++) begin
            @(negedge clk_i);
            if (!wdo_n_o || !rst_o) lows++;
        end
        check(lows == 0, "R9 held during reset", lows, 0);
        supply_low_i = 1'b0;
        wait_rst_low(n);
        wait_wdo_low(n);
        check(n == 25, "R9 count starts after release", n, 25);
    endtask

    task automatic t_slow_tick();
        int n;
        tick_div = 4;
        power_cycle(2'd0, n);
        check(n >= 197 && n <= 200, "R11 counts follow timebase", n, 200);
        tick_div = 1;
    endtask

    initial begin
        t_reset_state();
        t_por_codes();
        t_wd_codes();
        t_latch_and_start();
        t_start_restart();
        t_false_start();
        t_off();
        t_change();
        t_reset_hold();
        t_slow_tick();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk_i);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule